// File: doc/BRIEF.md
# Gamepad Serial Shift Interface

This block connects two eight-button game pads to a CPU bus through two byte-wide I/O locations. Software raises a strobe by writing a 1 into bit 0 of the first location, then lowers it by writing a 0. Lowering the strobe captures the buttons of every pad at once into per-pad shift registers. Each later read of a pad's location returns one button in bit 0, and successive reads step through that pad's buttons in a fixed order.

The pads present their buttons as one flat parallel vector. Pad `p` occupies bits `p*8 .. p*8+7`. Within a pad, bit 0 is A, bit 1 is B, bit 2 is Select, bit 3 is Start, bit 4 is Up, bit 5 is Down, bit 6 is Left and bit 7 is Right. A 1 means pressed. The read byte is registered, so it appears on `rd_data` one clock after the read cycle and holds until the next read that hits the block.

Top module: `padport_top`

## Requirements
- R1: A read at `BASE_ADDR` (0x4016) serves pad 0 and a read at `BASE_ADDR+1` (0x4017) serves pad 1. A read at any other address neither changes `rd_data` nor advances any pad.
- R2: A write to `BASE_ADDR` sets the strobe to `bus_wdata[0]`. A write to any other address, including `BASE_ADDR+1`, leaves the strobe unchanged.
- R3: When the strobe goes from 1 to 0, the buttons present in that write cycle are captured for every pad. Button changes after the capture do not alter the returned sequence.
- R4: After a capture, the reads of a pad return its buttons in the order A, B, Select, Start, Up, Down, Left, Right, which is vector bit 0 up to bit 7. A returned value of 1 means pressed.
- R5: While the strobe is 1, every read of a pad returns that pad's live A button, and its shift position does not move.
- R6: Once all eight buttons of a pad have been read, further reads of that pad return 1 until the next capture. Reads after reset and before any capture also return 1.
- R7: Each pad keeps its own shift position, and a read of one pad's address advances only that pad.
- R8: `rd_data` is 0 after reset. It is updated one clock after a read that hits the block, with bits 7 to 1 always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | CPU address |
| bus_rd | input | 1 | Read cycle qualifier |
| bus_wr | input | 1 | Write cycle qualifier |
| bus_wdata | input | 8 | CPU write data, only bit 0 used |
| pads_btn | input | 16 | Live button vectors, pad p at bits p*8+7..p*8 |
| rd_data | output | 8 | Registered read byte, button in bit 0 |

## Verification
The hardest situation to reach is a pad that is part-way through its sequence while the other pad is untouched, and then exhausted, with the live buttons already changed since the capture. The bench reaches it as follows:
- It walks a table of button patterns.
- For each pattern it captures, then inverts the live buttons.
- It then interleaves reads of both pads past the eighth button.

Directed sequences cover the rest:
- holding the strobe while A toggles,
- writes to the second address,
- stray reads to a foreign address,
- reads before the first capture.

// File: rtl/padport_pkg.sv
package padport_pkg;
   // Serial order of the buttons; the value is the bit index within a pad vector.
   typedef enum logic [2:0] {
      KEY_A      = 3'd0,
      KEY_B      = 3'd1,
      KEY_SELECT = 3'd2,
      KEY_START  = 3'd3,
      KEY_UP     = 3'd4,
      KEY_DOWN   = 3'd5,
      KEY_LEFT   = 3'd6,
      KEY_RIGHT  = 3'd7
   } pad_key_e;

   localparam int unsigned KEYS_PER_PAD = 8;
endpackage

// File: rtl/padport_decode.sv
module padport_decode #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_PADS  = 2,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4016
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_rd,
   input  logic                bus_wr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic                strobe_o,
   output logic [NUM_PADS-1:0] rd_hit_o
);
   logic strobe_q;
   logic ctl_wr;
   logic unused_wdata;

   assign ctl_wr       = bus_wr && (bus_addr == BASE_ADDR);
   assign unused_wdata = ^bus_wdata[DATA_W-1:1];

   always_ff @(posedge clk) begin
      if (!rst_n)      strobe_q <= 1'b0;
      else if (ctl_wr) strobe_q <= bus_wdata[0];
   end

   assign strobe_o = strobe_q;

   for (genvar p = 0; p < NUM_PADS; p++) begin : g_hit
      localparam logic [ADDR_W-1:0] PAD_ADDR = BASE_ADDR + ADDR_W'(p);
      assign rd_hit_o[p] = bus_rd && (bus_addr == PAD_ADDR);
   end

   AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == BASE_ADDR) |=> (strobe_o == $past(bus_wdata[0]))); // R2
   AST_STROBE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == BASE_ADDR) |=> $stable(strobe_o)); // R2
endmodule

// File: rtl/padport_shifter.sv
module padport_shifter #(
   parameter int unsigned BTN_W    = 8,
   parameter bit          FILL_BIT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             adv_i,
   input  logic [BTN_W-1:0] live_i,
   output logic             bit_o
);
   localparam int unsigned POS_W = $clog2(BTN_W + 1);
   localparam logic [POS_W-1:0] POS_END = POS_W'(BTN_W);

   logic [BTN_W-1:0] sr_q;
   logic [POS_W-1:0] pos_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr_q  <= {BTN_W{FILL_BIT}};
         pos_q <= POS_END;
      end else if (load_i) begin
         sr_q  <= live_i;
         pos_q <= '0;
      end else if (adv_i) begin
         sr_q  <= {FILL_BIT, sr_q[BTN_W-1:1]};
         if (pos_q != POS_END) pos_q <= pos_q + 1'b1;
      end
   end

   // While loading continuously, the live first button is the answer.
   assign bit_o = load_i ? live_i[0] : sr_q[0];

   AST_POS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q <= POS_END); // R6
   AST_DRAINED_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_q == POS_END) |-> (sr_q == {BTN_W{FILL_BIT}})); // R6
   AST_STROBE_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (pos_q == '0)); // R5
   AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && adv_i && pos_q != POS_END) |=> (pos_q == $past(pos_q) + 1'b1)); // R4
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_i) |=> ($stable(pos_q) && $stable(sr_q))); // R7
endmodule

// File: rtl/padport_top.sv
module padport_top
   import padport_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_PADS  = 2,
   parameter int unsigned BTN_W     = KEYS_PER_PAD,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4016,
   parameter bit          FILL_BIT  = 1'b1,
   parameter bit          REG_OUT   = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic                      bus_rd,
   input  logic                      bus_wr,
   input  logic [DATA_W-1:0]         bus_wdata,
   input  logic [NUM_PADS*BTN_W-1:0] pads_btn,
   output logic [DATA_W-1:0]         rd_data
);
   localparam int unsigned FIRST_KEY = int'(KEY_A);

   if (NUM_PADS < 1)        begin : g_bad_pads $error("NUM_PADS must be at least 1"); end
   if (BTN_W < 2)           begin : g_bad_btn  $error("BTN_W must be at least 2"); end
   if (DATA_W < 2)          begin : g_bad_data $error("DATA_W must be at least 2"); end
   if (FIRST_KEY != 0)      begin : g_bad_key  $error("first key must sit at bit 0"); end
   if (NUM_PADS >= (1 << ADDR_W)) begin : g_bad_addr $error("pads exceed address space"); end

   logic                strobe;
   logic [NUM_PADS-1:0] rd_hit;
   logic [NUM_PADS-1:0] pad_bit;
   logic                any_hit;
   logic [DATA_W-1:0]   rd_next;

   padport_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PADS(NUM_PADS), .BASE_ADDR(BASE_ADDR)
   ) u_decode (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .strobe_o(strobe), .rd_hit_o(rd_hit)
   );

   for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
      padport_shifter #(.BTN_W(BTN_W), .FILL_BIT(FILL_BIT)) u_shift (
         .clk(clk), .rst_n(rst_n), .load_i(strobe), .adv_i(rd_hit[p]),
         .live_i(pads_btn[p*BTN_W +: BTN_W]), .bit_o(pad_bit[p])
      );
   end

   assign any_hit = |rd_hit;
   assign rd_next = {{(DATA_W-1){1'b0}}, |(rd_hit & pad_bit)};

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n)       rd_data <= '0;
         else if (any_hit) rd_data <= rd_next;
      end
   end else begin : g_comb_out
      assign rd_data = any_hit ? rd_next : '0;
   end

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[DATA_W-1:1] == '0); // R8
   AST_ONE_PAD_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_hit)); // R7
   AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (REG_OUT && !(bus_rd && bus_addr >= BASE_ADDR && bus_addr < BASE_ADDR + ADDR_W'(NUM_PADS)))
      |=> $stable(rd_data)); // R1
endmodule

// File: tb/padport_top_test.sv
module padport_top_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] PAD0 = 16'h4016;
   localparam logic [15:0] PAD1 = 16'h4017;
   localparam int NVEC = 5;
   // Each entry: {pad1 buttons, pad0 buttons}
   localparam logic [15:0] VEC [NVEC] = '{16'h00FF, 16'hFF00, 16'hA55A, 16'h0180, 16'h3CC3};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [15:0] pads_btn = '0;
   logic [7:0]  rd_data;

   int checks = 0;
   int failures = 0;
   logic [7:0] got;

   padport_top uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .pads_btn(pads_btn), .rd_data(rd_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [15:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      v = rd_data;
   endtask

   task automatic capture();
      bus_write(PAD0, 8'h01);
      bus_write(PAD0, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R8 reset value", rd_data, 8'h00);
      rst_n = 1'b1;

      // R6: before any capture every read returns 1
      bus_read(PAD0, got); check("R6 pre-capture pad0", got, 8'h01);
      bus_read(PAD1, got); check("R6 pre-capture pad1", got, 8'h01);

      // Table walk: R3 R4 R6 R7 R8
      for (int v = 0; v < NVEC; v++) begin
         pads_btn = VEC[v];
         capture();
         pads_btn = ~VEC[v];
         for (int k = 0; k < 10; k++) begin
            bus_read(PAD0, got);
            check("R4 pad0 order", got, (k < 8) ? {7'b0, VEC[v][k]} : 8'h01);
            bus_read(PAD1, got);
            check("R4 pad1 order", got, (k < 8) ? {7'b0, VEC[v][8+k]} : 8'h01);
         end
      end

      // R5: strobe held high returns live A without advancing
      pads_btn = 16'h0001;
      bus_write(PAD0, 8'h01);
      bus_read(PAD0, got); check("R5 live A pressed", got, 8'h01);
      bus_read(PAD0, got); check("R5 no advance", got, 8'h01);
      pads_btn = 16'h0100;
      bus_read(PAD0, got); check("R5 live A released", got, 8'h00);
      bus_read(PAD1, got); check("R5 pad1 live A", got, 8'h01);
      pads_btn = 16'h0202;   // B pressed on both, A released
      bus_write(PAD0, 8'hFE);  // bit0=0 drops strobe, upper bits ignored
      pads_btn = 16'hFFFF;
      bus_read(PAD0, got); check("R3 first after fall is A", got, 8'h00);
      bus_read(PAD0, got); check("R3 second is B", got, 8'h01);

      // R7: pad1 still at A after pad0 advanced
      bus_read(PAD1, got); check("R7 pad1 untouched", got, 8'h00);
      bus_read(PAD1, got); check("R7 pad1 B", got, 8'h01);

      // R2: write to second address does not raise the strobe
      pads_btn = 16'h0000;
      capture();
      bus_write(PAD1, 8'h01);
      pads_btn = 16'hFFFF;
      bus_read(PAD0, got); check("R2 strobe not raised via pad1 addr", got, 8'h00);

      // R1: foreign address read neither updates rd_data nor advances
      pads_btn = 16'h0001;
      capture();
      bus_read(16'h4018, got); check("R1 foreign read holds", got, 8'h00);
      bus_read(PAD0, got); check("R1 pad0 still at A", got, 8'h01);
      bus_read(16'h4015, got); check("R1 foreign read holds value", got, 8'h01);
      bus_read(PAD0, got); check("R1 pad0 B", got, 8'h00);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule